// File: doc/BRIEF.md
# Serial Lane Status Register

This block is the 32-bit status word of one lane of a serial link port, as seen from a simple register bus. It combines three kinds of content in one word. Some fields are fixed identification constants. One field is a transmitter mode bit that software can write. The rest is live and accumulated lane state. The live state comes from four inputs that are already synchronous to the register clock: lane synchronisation, lane ready, receiver trained, and a one-cycle pulse for each line-code decode error.

Decode errors are counted in a 4-bit field that stops at 15 instead of wrapping. Two sticky flags record any level change of the synchronisation signal and of the training signal. A read strobe on this register returns the word one cycle later. The same read clears the counter and both flags. An event that arrives in the read cycle is not lost: it lands in the cleared state. Address decoding across lanes happens outside the block, which sees only a select line for its own word.

Top module: `lane_stat_reg`

## Requirements
- R1: Fixed fields read as follows: bits [31:24] = 0, bit 15 = 0, bits [5:4] = 0, bit 3 = 1, and bits [2:0] = 3'b011.
- R2: Bits [23:20] read the LANE_IDX parameter. Bit 19 reads TX_LONG (0 short reach, 1 long reach). Bits [17:16] read RX_REACH (00 short, 01 medium, 10 long, 11 reserved).
- R3: Bit 18 is the mode bit. It resets to TX_LONG. A cycle with reg_sel and reg_wr both high loads it from reg_wdata[18]. Every other bit of reg_wdata is ignored, and a write without reg_sel is ignored.
- R4: Bit 14 shows rx_trained_i, bit 13 shows lane_sync_i and bit 12 shows lane_ready_i, each as sampled in the read cycle.
- R5: Bits [11:8] count the clock cycles in which dec_err_i is high. The count holds at 15 and does not wrap.
- R6: A read returns the count as it stood before that cycle and then clears it. If dec_err_i is high in the read cycle, the count becomes 1.
- R7: Bit 7 is set by any level change of lane_sync_i, in either direction, and stays set until a read clears it. A change that falls in the read cycle is not shown by that read, and bit 7 is set afterwards.
- R8: Bit 6 behaves like bit 7, but for level changes of rx_trained_i.
- R9: A cycle with reg_sel and reg_rd both high puts the word on reg_rdata one cycle later. reg_rdata holds that value until the next such read. Only a read with reg_sel high clears anything.
- R10: After reset the count and both flags are 0. The previous-cycle copies used for edge detection are also 0, so an input that is high in the first cycle counts as a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | This lane's word is addressed |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data; only bit 18 is used |
| reg_rdata | output | 32 | Registered read data |
| lane_sync_i | input | 1 | Live lane synchronisation |
| lane_ready_i | input | 1 | Live lane ready |
| rx_trained_i | input | 1 | Live receiver-trained state |
| dec_err_i | input | 1 | One pulse per decode error |

## Verification
A faulty count shows up only when the register is read. A counter that wraps or misses an increment returns a wrong value in bits [11:8] on the next read, one cycle after the strobe. A flag that clears early, or misses an edge, appears at the first read after the event. An event lost in a read cycle appears only at the second read after it, so the reads are spaced to catch that. Corruption of the mode bit or of a constant field appears on every read from then on.

// File: rtl/lane_stat_pkg.sv
package lane_stat_pkg;

  localparam int ERR_CNT_W = 4;

  typedef struct packed {
    logic [7:0] port_id;
    logic [3:0] lane_id;
    logic       tx_reach;
    logic       tx_mode;
    logic [1:0] rx_reach;
    logic       pol_flip;
    logic       trn_live;
    logic       sync_live;
    logic       rdy_live;
    logic [3:0] err_cnt;
    logic       sync_chg;
    logic       trn_chg;
    logic [1:0] spare;
    logic       stat1_present;
    logic [2:0] extra_regs;
  } lane_word_t;

  // Saturating increment used by the error counter.
  function automatic logic [ERR_CNT_W-1:0] sat_inc(input logic [ERR_CNT_W-1:0] v);
    logic [ERR_CNT_W-1:0] top;
    top = '1;
    return (v == top) ? v : v + 1'b1;
  endfunction

  function automatic logic [31:0] pack_word(
    input logic [3:0] lane, input logic tx_t, input logic tx_m,
    input logic [1:0] rx_t, input logic trn, input logic snc,
    input logic rdy, input logic [3:0] cnt, input logic f_sync,
    input logic f_trn);
    lane_word_t w;
    w               = '0;
    w.lane_id       = lane;
    w.tx_reach      = tx_t;
    w.tx_mode       = tx_m;
    w.rx_reach      = rx_t;
    w.trn_live      = trn;
    w.sync_live     = snc;
    w.rdy_live      = rdy;
    w.err_cnt       = cnt;
    w.sync_chg      = f_sync;
    w.trn_chg       = f_trn;
    w.stat1_present = 1'b1;
    w.extra_regs    = 3'b011;
    return w;
  endfunction

endpackage

// File: rtl/lane_err_counter.sv
module lane_err_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         err_pulse,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    if (clr) cnt_d = err_pulse ? W'(1) : '0;
    else if (err_pulse) cnt_d = lane_stat_pkg::sat_inc(cnt_q);
    else cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  p_cnt_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && err_pulse && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_cnt_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !err_pulse) |=> $stable(cnt_q));
  p_cnt_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q <= W'(1));
endmodule

// File: rtl/lane_chg_flag.sv
module lane_chg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  input  logic clr,
  output logic flag
);
  logic prev_q;
  logic flag_q;
  logic edge_seen;

  assign edge_seen = level_in ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= level_in;
      flag_q <= clr ? edge_seen : (flag_q | edge_seen);
    end
  end

  assign flag = flag_q;

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  p_flag_catch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> flag_q);
  p_flag_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_seen) |=> !flag_q);
endmodule

// File: rtl/lane_stat_reg.sv
module lane_stat_reg #(
  parameter logic [3:0] LANE_IDX = 4'd0,
  parameter logic       TX_LONG  = 1'b0,
  parameter logic [1:0] RX_REACH = 2'b00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        lane_sync_i,
  input  logic        lane_ready_i,
  input  logic        rx_trained_i,
  input  logic        dec_err_i
);
  import lane_stat_pkg::*;

  localparam int NFLAG = 2;
  localparam int MODE_BIT = 18;

  logic                 rd_hit;
  logic                 wr_hit;
  logic                 tx_mode_q;
  logic [ERR_CNT_W-1:0] err_cnt;
  logic [NFLAG-1:0]     watch_lvl;
  logic [NFLAG-1:0]     chg_flag;
  logic [31:0]          word_now;
  logic [31:0]          rdata_q;
  logic                 unused_wdata;

  assign rd_hit = reg_sel & reg_rd;
  assign wr_hit = reg_sel & reg_wr;
  assign unused_wdata = ^{reg_wdata[31:MODE_BIT+1], reg_wdata[MODE_BIT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tx_mode_q <= TX_LONG;
    else if (wr_hit) tx_mode_q <= reg_wdata[MODE_BIT];
  end

  lane_err_counter #(.W(ERR_CNT_W)) u_err_cnt (
    .clk(clk), .rst_n(rst_n), .err_pulse(dec_err_i), .clr(rd_hit), .cnt(err_cnt)
  );

  // index 0: synchronisation, index 1: training
  assign watch_lvl = {rx_trained_i, lane_sync_i};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    lane_chg_flag u_flag (
      .clk(clk), .rst_n(rst_n), .level_in(watch_lvl[g]), .clr(rd_hit), .flag(chg_flag[g])
    );
  end

  assign word_now = pack_word(LANE_IDX, TX_LONG, tx_mode_q, RX_REACH, rx_trained_i,
                              lane_sync_i, lane_ready_i, err_cnt, chg_flag[0], chg_flag[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_hit) rdata_q <= word_now;
  end

  assign reg_rdata = rdata_q;

  p_fixed_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (reg_rdata[31:24] == 8'd0 && reg_rdata[15] == 1'b0 &&
                reg_rdata[5:0] == 6'b001011));
  p_id_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (reg_rdata[23:19] == {LANE_IDX, TX_LONG} && reg_rdata[17:16] == RX_REACH));
  p_mode_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> tx_mode_q == $past(reg_wdata[MODE_BIT]));
  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(tx_mode_q));
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> $stable(reg_rdata));
endmodule

// File: tb/lane_stat_reg_bench.sv
module lane_stat_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lane_sync_i = 1'b0, lane_ready_i = 1'b0, rx_trained_i = 1'b0, dec_err_i = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit rd_seen = 1'b0;
  logic b_sync = 1'b0, b_trn = 1'b0, b_rdy = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_exp = '0;

  always #4 clk = ~clk;

  lane_stat_reg #(.LANE_IDX(4'd6), .TX_LONG(1'b1), .RX_REACH(2'b01)) u_lane_stat_reg (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lane_sync_i(lane_sync_i),
    .lane_ready_i(lane_ready_i), .rx_trained_i(rx_trained_i), .dec_err_i(dec_err_i)
  );

  // Expected word from the requirement field positions (lane 6, long tx, medium rx).
  function automatic logic [31:0] ew(input logic [3:0] c, input logic f7, input logic f6,
                                     input logic s, input logic t, input logic r, input logic m);
    logic [31:0] w;
    w = 32'h0060_0000 | 32'h0008_0000 | 32'h0001_0000 | 32'h0000_000B;
    w[18] = m; w[14] = t; w[13] = s; w[12] = r;
    w[11:8] = c; w[7] = f7; w[6] = f6;
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= reg_sel && reg_rd;

  // Monitor: pop an expected item for each completed read.
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R9 unexpected read data", reg_rdata, 32'hx);
      else begin
        last_exp = exp_q.pop_front();
        check(tag_q.pop_front(), reg_rdata, last_exp);
      end
    end
  end

  task automatic apply_live();
    lane_sync_i = b_sync; rx_trained_i = b_trn; lane_ready_i = b_rdy;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); apply_live(); dec_err_i = 1'b0;
    end
  endtask

  task automatic errs(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); apply_live(); dec_err_i = 1'b1;
    end
    @(negedge clk); dec_err_i = 1'b0;
  endtask

  // Driver: read strobe, pushes the expected word for the monitor.
  task automatic rd(input logic [31:0] exp, input string tag, input logic err);
    @(negedge clk);
    apply_live(); dec_err_i = err; reg_sel = 1'b1; reg_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_sel = 1'b0; reg_rd = 1'b0; dec_err_i = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d, input logic sel);
    @(negedge clk);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1 R2 R10: reset word, mode equals TX_LONG
    rd(ew(4'd0, 0, 0, 0, 0, 0, 1), "R10 R1 R2 reset word", 1'b0);
    // R5 R6
    errs(3);
    rd(ew(4'd3, 0, 0, 0, 0, 0, 1), "R5 three errors", 1'b0);
    rd(ew(4'd0, 0, 0, 0, 0, 0, 1), "R6 cleared after read", 1'b0);
    errs(20);
    rd(ew(4'd15, 0, 0, 0, 0, 0, 1), "R5 saturation at 15", 1'b0);
    rd(ew(4'd0, 0, 0, 0, 0, 0, 1), "R6 clear after saturation", 1'b0);
    // R7 R4: sync rise and fall
    b_sync = 1'b1; idle(2);
    rd(ew(4'd0, 1, 0, 1, 0, 0, 1), "R7 sync rise flag", 1'b0);
    rd(ew(4'd0, 0, 0, 1, 0, 0, 1), "R7 flag cleared, live stays", 1'b0);
    b_sync = 1'b0; idle(2);
    rd(ew(4'd0, 1, 0, 0, 0, 0, 1), "R7 sync fall flag", 1'b0);
    rd(ew(4'd0, 0, 0, 0, 0, 0, 1), "R7 cleared again", 1'b0);
    // R8 R4: training
    b_trn = 1'b1; idle(2);
    rd(ew(4'd0, 0, 1, 0, 1, 0, 1), "R8 trained rise flag", 1'b0);
    rd(ew(4'd0, 0, 0, 0, 1, 0, 1), "R8 flag cleared", 1'b0);
    // R4: ready is live only
    b_rdy = 1'b1; idle(2);
    rd(ew(4'd0, 0, 0, 0, 1, 1, 1), "R4 ready live, no flag", 1'b0);
    // R3: mode bit writes
    wr(32'h0000_0000, 1'b1);
    rd(ew(4'd0, 0, 0, 0, 1, 1, 0), "R3 mode written 0", 1'b0);
    wr(32'hFFFB_FFFF, 1'b1);
    rd(ew(4'd0, 0, 0, 0, 1, 1, 0), "R3 other wdata bits ignored", 1'b0);
    wr(32'h0004_0000, 1'b0);
    rd(ew(4'd0, 0, 0, 0, 1, 1, 0), "R3 write without select ignored", 1'b0);
    wr(32'h0004_0000, 1'b1);
    rd(ew(4'd0, 0, 0, 0, 1, 1, 1), "R3 mode written 1", 1'b0);
    // R6: error in read cycle
    errs(2);
    rd(ew(4'd2, 0, 0, 0, 1, 1, 1), "R6 read returns old count", 1'b1);
    rd(ew(4'd1, 0, 0, 0, 1, 1, 1), "R6 error in read cycle kept", 1'b0);
    rd(ew(4'd0, 0, 0, 0, 1, 1, 1), "R6 then cleared", 1'b0);
    // R9: read without select clears nothing
    errs(4);
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    rd(ew(4'd4, 0, 0, 0, 1, 1, 1), "R9 unselected read no clear", 1'b0);
    // R7: edge in read cycle
    b_sync = 1'b1;
    rd(ew(4'd0, 0, 0, 1, 1, 1, 1), "R7 edge in read cycle hidden", 1'b0);
    rd(ew(4'd0, 1, 0, 1, 1, 1, 1), "R7 edge in read cycle kept", 1'b0);
    rd(ew(4'd0, 0, 0, 1, 1, 1, 1), "R7 cleared", 1'b0);
    // R9: data held between reads while inputs move
    b_sync = 1'b0; errs(3); idle(3);
    check("R9 read data held", reg_rdata, last_exp);
    idle(2);
    check("R9 all reads consumed", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule